// File: doc/BRIEF.md
# Shared Endpoint Packet Buffer Manager

This block manages one packet RAM of 32 KiB that a dual-role USB-style controller shares among all of its endpoints. The endpoint numbers run from 0 to 15. Endpoint 0 is the control endpoint and has a fixed one-packet window at the bottom of the RAM. Endpoints 1 to 15 each have a transmit side and a receive side, and software programs every such side with a base address, a power-of-two window size and a single- or double-packet mode.

On every access the block first resolves which side is meant, from the transaction kind (IN or OUT) and whether the controller acts as host or as peripheral. It then turns the byte offset of that access into a RAM address. It keeps a packet count per side and raises full and empty flags from it. In double-packet mode it keeps separate writer and reader half-selects, so that one half can be filled while the other is drained. A transmit side and a receive side with the same number may be given overlapping windows; the block does not check them against each other, because software promises never to use both at once.

An access is presented for one cycle with a last-beat marker. The block answers the cycle after with an accept bit and the resolved RAM address. Configuration errors and access errors are kept in sticky flags that only reset clears.

Top module: `ep_buf_mgr`

## Requirements
- R1: The access side is picked as follows. In peripheral mode (`host_mode`=0), IN selects the transmit side and OUT selects the receive side. In host mode, IN selects the receive side and OUT selects the transmit side.
- R2: Endpoint 0 always uses bytes 0 to 63 (address = offset mod 64). It holds one packet, which shows on bit 0 of both the transmit and the receive flag vectors. Configuration writes that name endpoint 0 have no effect.
- R3: `cfg_base` counts 8-byte units and `cfg_size`=n gives a window of 8·2^n bytes. In single-packet mode the address is base·8 + (offset mod window).
- R4: In double-packet mode each half is window/2 bytes. The writer and the reader each hold a half-select that starts at 0 and toggles on every accepted last beat. The address is base·8 + select·half + (offset mod half).
- R5: A side's capacity is 1 packet (single mode) or 2 packets (double mode). An accepted write with `acc_last` adds a packet and an accepted read with `acc_last` removes one. The full and empty flags show the new count from the cycle after the access.
- R6: A write to a full side, or a read from an empty one, is rejected (`rsp_ok`=0) and leaves the count and selects unchanged. It sets the sticky `ovf_err` or `unf_err` respectively.
- R7: A configuration is bad if n>10, if base·8 < 64, or if base·8 + window > 32768. A bad configuration sets the sticky `cfg_err` and disables that side, so every later access to it is rejected.
- R8: An access to a side that has been disabled or never configured is rejected and sets neither `ovf_err` nor `unf_err`.
- R9: Any configuration write to a side empties it and resets both of its half-selects to 0.
- R10: After reset every side is empty, no side is full, all sticky errors are clear and only endpoint 0 is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode | input | 1 | 1 = host role, 0 = peripheral role |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ep | input | 4 | Endpoint number to configure |
| cfg_rx | input | 1 | 1 = configure receive side, 0 = transmit side |
| cfg_base | input | 12 | Window base in 8-byte units |
| cfg_size | input | 4 | Size code n, window = 8·2^n bytes |
| cfg_dbl | input | 1 | Double-packet mode |
| acc_valid | input | 1 | Access request |
| acc_in | input | 1 | 1 = IN transaction, 0 = OUT |
| acc_ep | input | 4 | Endpoint number of the access |
| acc_wr | input | 1 | 1 = write into buffer, 0 = read out |
| acc_off | input | 13 | Byte offset within the packet |
| acc_last | input | 1 | Last beat of a packet |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_ok | output | 1 | Access accepted |
| rsp_addr | output | 15 | RAM byte address |
| tx_full | output | 16 | Per-endpoint transmit side full |
| tx_empty | output | 16 | Per-endpoint transmit side empty |
| rx_full | output | 16 | Per-endpoint receive side full |
| rx_empty | output | 16 | Per-endpoint receive side empty |
| cfg_err | output | 1 | Sticky bad-configuration flag |
| ovf_err | output | 1 | Sticky write-to-full flag |
| unf_err | output | 1 | Sticky read-from-empty flag |

## Verification
Each access gets its response (accept bit and address) exactly one cycle later, on `rsp_valid`. The driver queues the expected result when it presents the access, and a monitor pops and compares that result a little after the next rising edge. Full, empty and error flags, and the effect of a configuration write, also settle on that same edge. Those flags are therefore checked at the falling edge that ends each driver call, before the next stimulus goes out.

// File: rtl/ep_buf_pkg.sv
package ep_buf_pkg;
    localparam int NUM_EP      = 16;
    localparam int RAM_BYTES   = 32768;
    localparam int AW          = $clog2(RAM_BYTES);
    localparam int GRAN_LG     = 3;
    localparam int BASE_W      = AW - GRAN_LG;
    localparam int SZ_W        = 4;
    localparam int MAX_SZ_CODE = 10;
    localparam int OFF_W       = GRAN_LG + MAX_SZ_CODE;
    localparam int EP0_BYTES   = 64;
    localparam int NIDX        = 2 * NUM_EP;
    localparam int IDX_W       = $clog2(NIDX);
    localparam int EP_W        = $clog2(NUM_EP);

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [SZ_W-1:0]   sz;
        logic              dbl;
        logic              en;
    } ep_cfg_t;

    typedef struct packed {
        logic full;
        logic empty;
        logic wsel;
        logic rsel;
    } ep_stat_t;

    localparam ep_cfg_t EP0_CFG = '{base: '0, sz: SZ_W'($clog2(EP0_BYTES) - GRAN_LG),
                                    dbl: 1'b0, en: 1'b1};

    function automatic logic [AW:0] win_bytes(input logic [SZ_W-1:0] n);
        return (AW+1)'(1 << GRAN_LG) << n;
    endfunction

    function automatic logic cfg_bad(input logic [BASE_W-1:0] b, input logic [SZ_W-1:0] n);
        logic [AW:0] start;
        start = {1'b0, b, {GRAN_LG{1'b0}}};
        return (n > SZ_W'(MAX_SZ_CODE)) || (start < (AW+1)'(EP0_BYTES))
               || ((start + win_bytes(n)) > (AW+1)'(RAM_BYTES));
    endfunction
endpackage

// File: rtl/ep_cfg_regs.sv
module ep_cfg_regs
    import ep_buf_pkg::*;
#(
    parameter int N = NIDX
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(N)-1:0]     idx,
    input  ep_cfg_t                  val,
    output ep_cfg_t                  tbl [N],
    output logic [N-1:0]             clr,
    output logic                     cfg_err
);
    logic bad;
    assign bad = cfg_bad(val.base, val.sz);

    for (genvar i = 0; i < N; i++) begin : g_ent
        if (i == 0) begin : g_ep0
            assign tbl[i] = EP0_CFG;
            assign clr[i] = 1'b0;
        end else if (i == N/2) begin : g_hole
            assign tbl[i] = '0;
            assign clr[i] = 1'b0;
        end else begin : g_reg
            assign clr[i] = we && (idx == ($clog2(N))'(i));
            always_ff @(posedge clk) begin
                if (rst) begin
                    tbl[i] <= '0;
                end else if (clr[i]) begin
                    tbl[i]    <= val;
                    tbl[i].en <= !bad;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_err <= 1'b0;
        else if (we && bad)
            cfg_err <= 1'b1;
    end

    // R7
    cfg_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_err) |-> $past(we));
endmodule

// File: rtl/ep_occ.sv
module ep_occ (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 dbl,
    input  logic                 adv_wr,
    input  logic                 adv_rd,
    output ep_buf_pkg::ep_stat_t stat
);
    logic [1:0] cnt;
    logic       wsel, rsel;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            wsel <= 1'b0;
            rsel <= 1'b0;
        end else begin
            if (adv_wr) wsel <= dbl ? ~wsel : 1'b0;
            if (adv_rd) rsel <= dbl ? ~rsel : 1'b0;
            cnt <= cnt + {1'b0, adv_wr} - {1'b0, adv_rd};
        end
    end

    assign stat.full  = (cnt == (dbl ? 2'd2 : 2'd1));
    assign stat.empty = (cnt == 2'd0);
    assign stat.wsel  = wsel;
    assign stat.rsel  = rsel;

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= (dbl ? 2'd2 : 2'd1));
    // R5
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(stat.full && stat.empty));
endmodule

// File: rtl/ep_addr_gen.sv
module ep_addr_gen
    import ep_buf_pkg::*;
(
    input  ep_cfg_t           cfg,
    input  logic              sel,
    input  logic [OFF_W-1:0]  off,
    output logic [AW-1:0]     addr
);
    logic [AW:0]      win;
    logic [AW:0]      slot;
    logic [OFF_W-1:0] mask;
    logic [AW-1:0]    half_ofs;

    always_comb begin
        win      = win_bytes(cfg.sz);
        slot     = cfg.dbl ? (win >> 1) : win;
        mask     = OFF_W'(slot - 1'b1);
        half_ofs = (cfg.dbl && sel) ? AW'(slot) : '0;
        addr     = {cfg.base, {GRAN_LG{1'b0}}} + half_ofs + AW'(off & mask);
    end
endmodule

// File: rtl/ep_buf_mgr.sv
module ep_buf_mgr
    import ep_buf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_mode,
    input  logic                 cfg_we,
    input  logic [EP_W-1:0]      cfg_ep,
    input  logic                 cfg_rx,
    input  logic [BASE_W-1:0]    cfg_base,
    input  logic [SZ_W-1:0]      cfg_size,
    input  logic                 cfg_dbl,
    input  logic                 acc_valid,
    input  logic                 acc_in,
    input  logic [EP_W-1:0]      acc_ep,
    input  logic                 acc_wr,
    input  logic [OFF_W-1:0]     acc_off,
    input  logic                 acc_last,
    output logic                 rsp_valid,
    output logic                 rsp_ok,
    output logic [AW-1:0]        rsp_addr,
    output logic [NUM_EP-1:0]    tx_full,
    output logic [NUM_EP-1:0]    tx_empty,
    output logic [NUM_EP-1:0]    rx_full,
    output logic [NUM_EP-1:0]    rx_empty,
    output logic                 cfg_err,
    output logic                 ovf_err,
    output logic                 unf_err
);
    ep_cfg_t          tbl  [NIDX];
    ep_stat_t         stat [NIDX];
    logic [NIDX-1:0]  clr;
    logic [NIDX-1:0]  adv_wr, adv_rd;
    ep_cfg_t          cfg_val;
    logic             to_rx;
    logic [IDX_W-1:0] idx;
    ep_cfg_t          cur_cfg;
    ep_stat_t         cur_st;
    logic             blocked, accept;
    logic [AW-1:0]    addr;

    assign cfg_val = '{base: cfg_base, sz: cfg_size, dbl: cfg_dbl, en: 1'b1};

    ep_cfg_regs #(.N(NIDX)) u_cfg (
        .clk(clk), .rst(rst),
        .we(cfg_we && (cfg_ep != '0)),
        .idx({cfg_rx, cfg_ep}),
        .val(cfg_val),
        .tbl(tbl), .clr(clr), .cfg_err(cfg_err)
    );

    // role-dependent side selection
    assign to_rx   = host_mode ? acc_in : !acc_in;
    assign idx     = (acc_ep == '0) ? '0 : {to_rx, acc_ep};
    assign cur_cfg = tbl[idx];
    assign cur_st  = stat[idx];
    assign blocked = acc_wr ? cur_st.full : cur_st.empty;
    assign accept  = acc_valid && cur_cfg.en && !blocked;

    for (genvar i = 0; i < NIDX; i++) begin : g_occ
        assign adv_wr[i] = accept && acc_last && acc_wr && (idx == IDX_W'(i));
        assign adv_rd[i] = accept && acc_last && !acc_wr && (idx == IDX_W'(i));
        if (i == NUM_EP) begin : g_hole
            assign stat[i] = '{full: 1'b0, empty: 1'b1, wsel: 1'b0, rsel: 1'b0};
        end else begin : g_side
            ep_occ u_occ (
                .clk(clk), .rst(rst), .clr(clr[i]), .dbl(tbl[i].dbl),
                .adv_wr(adv_wr[i]), .adv_rd(adv_rd[i]), .stat(stat[i])
            );
        end
    end

    ep_addr_gen u_addr (
        .cfg(cur_cfg),
        .sel(acc_wr ? cur_st.wsel : cur_st.rsel),
        .off(acc_off),
        .addr(addr)
    );

    for (genvar e = 0; e < NUM_EP; e++) begin : g_flags
        assign tx_full[e]  = stat[e].full;
        assign tx_empty[e] = stat[e].empty;
        if (e == 0) begin : g_ep0
            assign rx_full[e]  = stat[0].full;
            assign rx_empty[e] = stat[0].empty;
        end else begin : g_rx
            assign rx_full[e]  = stat[NUM_EP+e].full;
            assign rx_empty[e] = stat[NUM_EP+e].empty;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_addr  <= '0;
            ovf_err   <= 1'b0;
            unf_err   <= 1'b0;
        end else begin
            rsp_valid <= acc_valid;
            rsp_ok    <= accept;
            rsp_addr  <= addr;
            if (acc_valid && cur_cfg.en && blocked) begin
                if (acc_wr) ovf_err <= 1'b1;
                else        unf_err <= 1'b1;
            end
        end
    end

    // R6
    ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_err) |-> $past(acc_valid && acc_wr));
    // R6
    unf_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(unf_err) |-> $past(acc_valid && !acc_wr));
    // R2
    ep0_window_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_ok && $past(acc_ep) == '0) |-> rsp_addr < AW'(EP0_BYTES));
    // R8
    ok_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_ok |-> rsp_valid);
endmodule

// File: tb/ep_buf_mgr_test.sv
`timescale 1ns/1ps
module ep_buf_mgr_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_mode = 1'b0;
    logic        cfg_we = 1'b0, cfg_rx = 1'b0, cfg_dbl = 1'b0;
    logic [3:0]  cfg_ep = '0, cfg_size = '0;
    logic [11:0] cfg_base = '0;
    logic        acc_valid = 1'b0, acc_in = 1'b0, acc_wr = 1'b0, acc_last = 1'b0;
    logic [3:0]  acc_ep = '0;
    logic [12:0] acc_off = '0;
    logic        rsp_valid, rsp_ok;
    logic [14:0] rsp_addr;
    logic [15:0] tx_full, tx_empty, rx_full, rx_empty;
    logic        cfg_err, ovf_err, unf_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        logic        ok;
        logic [14:0] addr;
        int          req;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    ep_buf_mgr uut (
        .clk(clk), .rst(rst), .host_mode(host_mode),
        .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_rx(cfg_rx), .cfg_base(cfg_base),
        .cfg_size(cfg_size), .cfg_dbl(cfg_dbl),
        .acc_valid(acc_valid), .acc_in(acc_in), .acc_ep(acc_ep), .acc_wr(acc_wr),
        .acc_off(acc_off), .acc_last(acc_last),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_addr(rsp_addr),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
        .cfg_err(cfg_err), .ovf_err(ovf_err), .unf_err(unf_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops one expected item per response
    always @(posedge clk) begin
        #1;
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk("R1 unexpected response", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk($sformatf("R%0d ok", e.req), {31'd0, rsp_ok}, {31'd0, e.ok});
                if (e.ok && rsp_ok)
                    chk($sformatf("R%0d addr", e.req), {17'd0, rsp_addr}, {17'd0, e.addr});
            end
        end
    end

    task automatic cfg(input logic rx, input logic [3:0] ep, input logic [11:0] base,
                       input logic [3:0] sz, input logic dbl);
        @(negedge clk);
        cfg_we = 1'b1; cfg_rx = rx; cfg_ep = ep; cfg_base = base; cfg_size = sz; cfg_dbl = dbl;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic acc(input logic in, input logic [3:0] ep, input logic wr,
                       input logic [12:0] off, input logic last,
                       input logic eok, input logic [14:0] eaddr, input int req);
        exp_t e;
        @(negedge clk);
        acc_valid = 1'b1; acc_in = in; acc_ep = ep; acc_wr = wr; acc_off = off; acc_last = last;
        e.ok = eok; e.addr = eaddr; e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 tx_empty", {16'd0, tx_empty}, 32'hFFFF);
        chk("R10 rx_empty", {16'd0, rx_empty}, 32'hFFFF);
        chk("R10 full", {tx_full, rx_full}, 32'd0);
        chk("R10 errs", {29'd0, cfg_err, ovf_err, unf_err}, 32'd0);

        // R8 unconfigured endpoint: rejected, no error flag
        acc(1'b1, 4'd5, 1'b1, 13'd0, 1'b1, 1'b0, 15'd0, 8);
        acc(1'b0, 4'd5, 1'b0, 13'd0, 1'b1, 1'b0, 15'd0, 8);
        chk("R8 no err", {30'd0, ovf_err, unf_err}, 32'd0);

        // R2 endpoint 0 fixed window, peripheral IN -> transmit side
        acc(1'b1, 4'd0, 1'b1, 13'd5, 1'b0, 1'b1, 15'd5, 2);
        acc(1'b1, 4'd0, 1'b1, 13'd70, 1'b1, 1'b1, 15'd6, 2);
        chk("R2 ep0 full tx", {31'd0, tx_full[0]}, 32'd1);
        chk("R2 ep0 full rx", {31'd0, rx_full[0]}, 32'd1);
        // R6 write to full
        acc(1'b1, 4'd0, 1'b1, 13'd0, 1'b1, 1'b0, 15'd0, 6);
        chk("R6 ovf set", {31'd0, ovf_err}, 32'd1);
        chk("R6 still full", {31'd0, tx_full[0]}, 32'd1);
        acc(1'b0, 4'd0, 1'b0, 13'd2, 1'b1, 1'b1, 15'd2, 2);
        chk("R5 ep0 empty", {31'd0, tx_empty[0]}, 32'd1);

        // R3 single-packet window: tx ep1 base 16 (byte 128), 128 bytes
        cfg(1'b0, 4'd1, 12'd16, 4'd4, 1'b0);
        acc(1'b1, 4'd1, 1'b1, 13'd10, 1'b0, 1'b1, 15'd138, 3);
        acc(1'b1, 4'd1, 1'b1, 13'd130, 1'b1, 1'b1, 15'd130, 3);
        chk("R5 tx1 full", {31'd0, tx_full[1]}, 32'd1);

        // R4 double-packet rx ep1 sharing the same window, halves of 64
        cfg(1'b1, 4'd1, 12'd16, 4'd4, 1'b1);
        acc(1'b0, 4'd1, 1'b1, 13'd3, 1'b1, 1'b1, 15'd131, 4);
        chk("R5 rx1 half", {30'd0, rx_full[1], rx_empty[1]}, 32'd0);
        acc(1'b0, 4'd1, 1'b1, 13'd3, 1'b1, 1'b1, 15'd195, 4);
        chk("R5 rx1 full", {31'd0, rx_full[1]}, 32'd1);
        acc(1'b0, 4'd1, 1'b1, 13'd3, 1'b1, 1'b0, 15'd0, 6);
        acc(1'b0, 4'd1, 1'b0, 13'd0, 1'b1, 1'b1, 15'd128, 4);
        acc(1'b0, 4'd1, 1'b0, 13'd1, 1'b1, 1'b1, 15'd193, 4);
        chk("R5 rx1 empty", {31'd0, rx_empty[1]}, 32'd1);
        chk("R6 unf clear", {31'd0, unf_err}, 32'd0);

        // R1 host mode: IN -> rx side, OUT -> tx side
        host_mode = 1'b1;
        acc(1'b1, 4'd1, 1'b0, 13'd0, 1'b1, 1'b0, 15'd0, 6);
        chk("R6 unf set", {31'd0, unf_err}, 32'd1);
        acc(1'b0, 4'd1, 1'b0, 13'd4, 1'b1, 1'b1, 15'd132, 1);
        chk("R1 host OUT drains tx", {31'd0, tx_empty[1]}, 32'd1);
        acc(1'b1, 4'd1, 1'b1, 13'd9, 1'b1, 1'b1, 15'd137, 1);
        chk("R1 host IN fills rx", {30'd0, rx_empty[1], tx_empty[1]}, 32'd1);

        // R9 reconfigure clears count and selects
        cfg(1'b1, 4'd1, 12'd16, 4'd4, 1'b1);
        chk("R9 rx1 empty", {31'd0, rx_empty[1]}, 32'd1);
        acc(1'b1, 4'd1, 1'b1, 13'd9, 1'b1, 1'b1, 15'd137, 9);
        host_mode = 1'b0;

        // R7 range checks
        chk("R7 cfg clear", {31'd0, cfg_err}, 32'd0);
        cfg(1'b0, 4'd2, 12'd4090, 4'd3, 1'b0);
        chk("R7 past end", {31'd0, cfg_err}, 32'd1);
        acc(1'b1, 4'd2, 1'b1, 13'd0, 1'b1, 1'b0, 15'd0, 7);
        cfg(1'b0, 4'd2, 12'd4088, 4'd3, 1'b0);
        acc(1'b1, 4'd2, 1'b1, 13'd63, 1'b0, 1'b1, 15'd32767, 7);
        cfg(1'b0, 4'd3, 12'd7, 4'd0, 1'b0);
        acc(1'b1, 4'd3, 1'b1, 13'd0, 1'b1, 1'b0, 15'd0, 7);
        cfg(1'b0, 4'd3, 12'd8, 4'd10, 1'b0);
        acc(1'b1, 4'd3, 1'b1, 13'd8191, 1'b0, 1'b1, 15'd8255, 3);
        cfg(1'b0, 4'd4, 12'd8, 4'd11, 1'b0);
        acc(1'b1, 4'd4, 1'b1, 13'd0, 1'b1, 1'b0, 15'd0, 7);

        // R2 configuration of endpoint 0 is ignored
        cfg(1'b0, 4'd0, 12'd100, 4'd5, 1'b1);
        acc(1'b1, 4'd0, 1'b1, 13'd1, 1'b0, 1'b1, 15'd1, 2);

        repeat (3) @(negedge clk);
        chk("R8 queue drained", exp_q.size(), 32'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule